// File: doc/BRIEF.md
# Interprocessor Interrupt Command Unit

This block is the register slice of one processor's local interrupt controller that sends interprocessor messages. Software reaches it through a simple word-wide register port. There are four registers: a processor-number register, an end-of-interrupt register, a register that holds the controller's enable bit and its spurious vector, and a 64-bit command register that is split into a low word and a high word.

Software first writes the destination processor number into the high command word. Writing the low command word then starts a send. The unit combines the destination shorthand with the destination number and the unit's own processor number, and from them it builds one target bit per processor. It sets a read-only pending bit and offers the message on a valid/ready output port. The pending bit clears when that port accepts the message. Software polls the pending bit and waits for 0 before it writes the next command.

Top module: `ipi_cmd_unit`

## Requirements
- R1: After reset, reads return 0 from the processor-number register (offset 0x020), the low command word (0x300) and the high command word (0x310). The enable/spurious register (0x0F0) reads 0x000000FF, which means the unit is disabled and the vector is 0xFF. msgValid is 0.
- R2: A write to 0x020 keeps bits 31:24 as the unit's own processor number. The register reads back with all other bits at 0.
- R3: Any write to 0x0B0 raises eoiStrobe for exactly one cycle, in the cycle after the write. A read of 0x0B0 returns 0.
- R4: A write to 0x0F0 keeps bits 7:0 (vector) and bit 8 (enable, 1 = on). Bits 31:9 read as 0. The high word at 0x310 keeps bits 31:24 (destination number), and all its other bits read as 0.
- R5: The low command word keeps bits 7:0 (vector), 10:8 (delivery mode), 11 (destination mode, 0 = physical), 14 (level), 15 (trigger) and 19:18 (shorthand). It reads back as the written value ANDed with 0x000CCFFF. Bit 12 reads the pending flag, and software cannot write it.
- R6: A low-word write that is accepted while enable = 1, with destination mode 0 and a delivery mode other than 011 or 111, sets pending. From the next cycle on, msgValid = 1 and bit 12 reads 1. The message carries msgVector = bits 7:0, msgMode = bits 10:8, msgLevel = bit 14 and msgTrigger = bit 15 of the write.
- R7: Each bit i of msgTargets stands for processor i, and the shorthand decides which bits are set. Shorthand 00 sets only bit i = destination number. Shorthand 01 sets only the unit's own number. Shorthand 10 sets all bits. Shorthand 11 sets all bits except the unit's own.
- R8: While msgValid = 1 and msgReady = 0, msgValid and every payload output hold their values. After a cycle in which msgValid and msgReady are both 1, msgValid and the pending bit are 0.
- R9: A low-word write made while pending = 1 is ignored. The stored word and the outstanding message do not change.
- R10: A low-word write whose delivery mode is 011 or 111 is stored, but it sets no pending flag and sends nothing.
- R11: A low-word write with destination mode 1 (logical) is stored, but it sets no pending flag and sends nothing.
- R12: While enable = 0, low-word writes are stored, but they set no pending flag and send nothing.
- R13: With shorthand 00 and a destination number of NUM_CPU or more, the message is still sent, with an all-zero target mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Byte offset of the register being accessed |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| eoiStrobe | output | 1 | One-cycle end-of-interrupt pulse |
| msgValid | output | 1 | Outbound message valid (equals pending) |
| msgReady | input | 1 | Outbound port accepts the message |
| msgTargets | output | NUM_CPU | Target processor mask |
| msgVector | output | 8 | Message vector |
| msgMode | output | 3 | Delivery mode |
| msgLevel | output | 1 | Level bit |
| msgTrigger | output | 1 | Trigger bit |

## Verification
The assertions assume that busAddr and busWrData are stable around each clock edge, that a write occupies one cycle, and that msgReady is a plain level with no dependence on msgValid inside the same cycle. The bench changes every input only at the falling edge and drives each write for exactly one cycle. It holds msgReady low for a random 0 to 3 cycles before it pulses it for one cycle. Processor and destination numbers are drawn from a range a little wider than NUM_CPU, so that the empty-mask case of R13 also shows up in the random runs.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam logic [11:0] OFF_ID   = 12'h020;
  localparam logic [11:0] OFF_EOI  = 12'h0B0;
  localparam logic [11:0] OFF_SPUR = 12'h0F0;
  localparam logic [11:0] OFF_LOW  = 12'h300;
  localparam logic [11:0] OFF_HIGH = 12'h310;

  // Writable bits of the low command word (status bit 12 excluded)
  localparam logic [31:0] LOW_KEEP = 32'h000CCFFF;
  localparam logic [8:0]  SPUR_RST = 9'h0FF;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'b000,
    DM_LOWPRI = 3'b001,
    DM_SMI    = 3'b010,
    DM_RSV_A  = 3'b011,
    DM_NMI    = 3'b100,
    DM_INIT   = 3'b101,
    DM_START  = 3'b110,
    DM_RSV_B  = 3'b111
  } dmode_e;

  typedef enum logic [1:0] {
    SH_FIELD   = 2'b00,
    SH_SELF    = 2'b01,
    SH_ALL     = 2'b10,
    SH_OTHERS  = 2'b11
  } shorthand_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrId;
    logic wrSpur;
    logic wrHigh;
    logic wrLow;
    logic launch;
  } ctrl_s;

  function automatic logic modeReserved(input logic [2:0] m);
    return (m == DM_RSV_A) || (m == DM_RSV_B);
  endfunction
endpackage

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [2:0]        cmdMode,
  input  logic              cmdLogical,
  input  logic              unitEnable,
  input  logic              msgReady,
  output ctrl_s             strobes,
  output logic              pending,
  output logic              eoiStrobe
);
  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(OFF_ID);
  localparam logic [ADDR_W-1:0] A_EOI  = ADDR_W'(OFF_EOI);
  localparam logic [ADDR_W-1:0] A_SPUR = ADDR_W'(OFF_SPUR);
  localparam logic [ADDR_W-1:0] A_LOW  = ADDR_W'(OFF_LOW);
  localparam logic [ADDR_W-1:0] A_HIGH = ADDR_W'(OFF_HIGH);

  logic sendable;

  always_comb begin
    sendable        = unitEnable && !cmdLogical && !modeReserved(cmdMode);
    strobes.wrId    = busWrEn && (busAddr == A_ID);
    strobes.wrSpur  = busWrEn && (busAddr == A_SPUR);
    strobes.wrHigh  = busWrEn && (busAddr == A_HIGH);
    strobes.wrLow   = busWrEn && (busAddr == A_LOW) && !pending;
    strobes.launch  = strobes.wrLow && sendable;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending   <= 1'b0;
      eoiStrobe <= 1'b0;
    end else begin
      eoiStrobe <= busWrEn && (busAddr == A_EOI);
      if (strobes.launch)
        pending <= 1'b1;
      else if (pending && msgReady)
        pending <= 1'b0;
    end
  end
endmodule

// File: rtl/ipi_regs.sv
module ipi_regs
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_s              strobes,
  input  logic               pending,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWrData,
  output logic [31:0]        busRdData,
  output logic               unitEnable,
  output logic [NUM_CPU-1:0] msgTargets,
  output logic [7:0]         msgVector,
  output logic [2:0]         msgMode,
  output logic               msgLevel,
  output logic               msgTrigger
);
  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(OFF_ID);
  localparam logic [ADDR_W-1:0] A_SPUR = ADDR_W'(OFF_SPUR);
  localparam logic [ADDR_W-1:0] A_LOW  = ADDR_W'(OFF_LOW);
  localparam logic [ADDR_W-1:0] A_HIGH = ADDR_W'(OFF_HIGH);

  logic [7:0]         selfId;
  logic [7:0]         destId;
  logic [8:0]         spurReg;
  logic [31:0]        lowReg;
  logic [NUM_CPU-1:0] newMask;
  shorthand_e         shSel;

  assign unitEnable = spurReg[8];
  assign shSel      = shorthand_e'(busWrData[19:18]);

  // Target mask expansion, one bit per processor
  for (genvar i = 0; i < NUM_CPU; i++) begin : g_mask
    logic isSelf;
    logic isDest;
    assign isSelf = (selfId == 8'(i));
    assign isDest = (destId == 8'(i));
    always_comb begin
      unique case (shSel)
        SH_FIELD:  newMask[i] = isDest;
        SH_SELF:   newMask[i] = isSelf;
        SH_ALL:    newMask[i] = 1'b1;
        SH_OTHERS: newMask[i] = !isSelf;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selfId     <= '0;
      destId     <= '0;
      spurReg    <= SPUR_RST;
      lowReg     <= '0;
      msgTargets <= '0;
      msgVector  <= '0;
      msgMode    <= '0;
      msgLevel   <= 1'b0;
      msgTrigger <= 1'b0;
    end else begin
      if (strobes.wrId)   selfId  <= busWrData[31:24];
      if (strobes.wrHigh) destId  <= busWrData[31:24];
      if (strobes.wrSpur) spurReg <= busWrData[8:0];
      if (strobes.wrLow)  lowReg  <= busWrData & LOW_KEEP;
      if (strobes.launch) begin
        msgTargets <= newMask;
        msgVector  <= busWrData[7:0];
        msgMode    <= busWrData[10:8];
        msgLevel   <= busWrData[14];
        msgTrigger <= busWrData[15];
      end
    end
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == A_ID)        busRdData = {selfId, 24'h0};
    else if (busAddr == A_SPUR) busRdData = {23'h0, spurReg};
    else if (busAddr == A_HIGH) busRdData = {destId, 24'h0};
    else if (busAddr == A_LOW)  busRdData = lowReg | {19'h0, pending, 12'h0};
  end
endmodule

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWrData,
  output logic [31:0]        busRdData,
  output logic               eoiStrobe,
  output logic               msgValid,
  input  logic               msgReady,
  output logic [NUM_CPU-1:0] msgTargets,
  output logic [7:0]         msgVector,
  output logic [2:0]         msgMode,
  output logic               msgLevel,
  output logic               msgTrigger
);
  ctrl_s strobes;
  logic  pending;
  logic  unitEnable;

  assign msgValid = pending;

  ipi_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busWrEn    (busWrEn),
    .busAddr    (busAddr),
    .cmdMode    (busWrData[10:8]),
    .cmdLogical (busWrData[11]),
    .unitEnable (unitEnable),
    .msgReady   (msgReady),
    .strobes    (strobes),
    .pending    (pending),
    .eoiStrobe  (eoiStrobe)
  );

  ipi_regs #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .pending    (pending),
    .busAddr    (busAddr),
    .busWrData  (busWrData),
    .busRdData  (busRdData),
    .unitEnable (unitEnable),
    .msgTargets (msgTargets),
    .msgVector  (msgVector),
    .msgMode    (msgMode),
    .msgLevel   (msgLevel),
    .msgTrigger (msgTrigger)
  );
endmodule

// File: rtl/ipi_cmd_unit_chk.sv
module ipi_cmd_unit_chk
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int ADDR_W  = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic               busWrEn,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [3:0]         cmdBits,
  input logic               eoiStrobe,
  input logic               msgValid,
  input logic               msgReady,
  input logic [NUM_CPU-1:0] msgTargets,
  input logic [7:0]         msgVector,
  input logic [2:0]         msgMode,
  input logic               msgLevel,
  input logic               msgTrigger
);
  localparam logic [ADDR_W-1:0] A_EOI = ADDR_W'(OFF_EOI);
  localparam logic [ADDR_W-1:0] A_LOW = ADDR_W'(OFF_LOW);

  // R8: payload held while the port stalls
  a_r8_hold_payload: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgTargets) && $stable(msgVector)
      && $stable(msgMode) && $stable(msgLevel) && $stable(msgTrigger)));

  // R8: acceptance drops valid
  a_r8_accept_clears: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgReady) |=> !msgValid);

  // R3: strobe only follows an end-of-interrupt write
  a_r3_eoi_cause: assert property (@(posedge clk) disable iff (!rstN)
    eoiStrobe |-> $past(busWrEn && (busAddr == A_EOI)));

  // R6, R10, R11: a new message follows only a physical, non-reserved low-word write
  a_r6_launch_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(msgValid) |-> $past(busWrEn && (busAddr == A_LOW) && !cmdBits[3]
      && !modeReserved(cmdBits[2:0])));

  // R9: a low-word write while pending leaves the message alone
  a_r9_no_overwrite: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && busWrEn && (busAddr == A_LOW)) |=>
      ($stable(msgTargets) && $stable(msgVector) && $stable(msgMode)));
endmodule

bind ipi_cmd_unit ipi_cmd_unit_chk #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busWrEn    (busWrEn),
  .busAddr    (busAddr),
  .cmdBits    (busWrData[11:8]),
  .eoiStrobe  (eoiStrobe),
  .msgValid   (msgValid),
  .msgReady   (msgReady),
  .msgTargets (msgTargets),
  .msgVector  (msgVector),
  .msgMode    (msgMode),
  .msgLevel   (msgLevel),
  .msgTrigger (msgTrigger)
);

// File: tb/test_ipi_cmd_unit.sv
module test_ipi_cmd_unit;
  localparam int NUM_CPU = 8;
  localparam int ADDR_W  = 12;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               busWrEn = 1'b0;
  logic [ADDR_W-1:0]  busAddr = '0;
  logic [31:0]        busWrData = '0;
  logic [31:0]        busRdData;
  logic               eoiStrobe;
  logic               msgValid;
  logic               msgReady = 1'b0;
  logic [NUM_CPU-1:0] msgTargets;
  logic [7:0]         msgVector;
  logic [2:0]         msgMode;
  logic               msgLevel;
  logic               msgTrigger;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ipi_cmd_unit #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) i_ipi_cmd_unit (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  function automatic logic [NUM_CPU-1:0] expMask(input int sh, input int id, input int dest);
    logic [NUM_CPU-1:0] m;
    for (int i = 0; i < NUM_CPU; i++) begin
      case (sh)
        0: m[i] = (i == dest);
        1: m[i] = (i == id);
        2: m[i] = 1'b1;
        default: m[i] = (i != id);
      endcase
    end
    return m;
  endfunction

  function automatic bit expSend(input bit en, input logic [31:0] w);
    return en && !w[11] && (w[10:8] != 3'b011) && (w[10:8] != 3'b111);
  endfunction

  // Accept an outstanding message after 'stall' cycles, probing ignored writes meanwhile
  task automatic drain(input int stall, input logic [NUM_CPU-1:0] expT, input logic [31:0] storedLow);
    logic [31:0] r;
    for (int k = 0; k < stall; k++) begin
      busWrite(12'h300, $urandom & 32'hFFFFF0FF);
      busRead(12'h300, r);
      check("R9 low word unchanged while pending", r, storedLow | 32'h1000);
      check("R8 valid held during stall", {31'h0, msgValid}, 32'h1);
      check("R9 targets unchanged", 32'(msgTargets), 32'(expT));
    end
    @(negedge clk); msgReady = 1'b1;
    @(negedge clk); msgReady = 1'b0;
    check("R8 valid cleared after accept", {31'h0, msgValid}, 32'h0);
    busRead(12'h300, r);
    check("R8 pending bit cleared", r, storedLow);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] w;
    int id, dest, selfNum;
    bit en;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRead(12'h020, r); check("R1 id reset", r, 32'h0);
    busRead(12'h0F0, r); check("R1 spurious reset", r, 32'h000000FF);
    busRead(12'h300, r); check("R1 low reset", r, 32'h0);
    busRead(12'h310, r); check("R1 high reset", r, 32'h0);
    check("R1 valid reset", {31'h0, msgValid}, 32'h0);

    // R2, R4 field masking
    busWrite(12'h020, 32'hA5FFFFFF); busRead(12'h020, r); check("R2 id readback", r, 32'hA5000000);
    busWrite(12'h0F0, 32'hFFFFFE3C); busRead(12'h0F0, r); check("R4 spurious readback", r, 32'h0000003C);
    busWrite(12'h310, 32'h03FFFFFF); busRead(12'h310, r); check("R4 high readback", r, 32'h03000000);

    // R12 disabled: stored but not sent
    busWrite(12'h300, 32'h00004021); busRead(12'h300, r);
    check("R12 stored while disabled", r, 32'h00004021);
    check("R12 no send while disabled", {31'h0, msgValid}, 32'h0);

    // R3 end-of-interrupt pulse
    @(negedge clk); busWrEn = 1'b1; busAddr = 12'h0B0; busWrData = 32'hDEADBEEF;
    @(negedge clk); busWrEn = 1'b0;
    check("R3 eoi pulse high", {31'h0, eoiStrobe}, 32'h1);
    @(negedge clk);
    check("R3 eoi pulse one cycle", {31'h0, eoiStrobe}, 32'h0);
    busRead(12'h0B0, r); check("R3 eoi reads zero", r, 32'h0);

    // R5 low word mask incl. attempt on status bit
    busWrite(12'h300, 32'hFFFFFFFF); busRead(12'h300, r);
    check("R5 low mask (reserved+logical, no send)", r, 32'h000CCFFF);
    check("R11 logical not sent", {31'h0, msgValid}, 32'h0);

    // R13 out-of-range destination, enabled
    busWrite(12'h0F0, 32'h1FF);
    busWrite(12'h020, 32'h02000000);
    busWrite(12'h310, 32'h09000000);
    busWrite(12'h300, 32'h00000512);
    check("R13 sent with out-of-range dest", {31'h0, msgValid}, 32'h1);
    check("R13 empty mask", 32'(msgTargets), 32'h0);
    check("R6 mode INIT", 32'(msgMode), 32'h5);
    drain(1, '0, 32'h00000512);

    // R10 reserved mode
    busWrite(12'h300, 32'h00000700); busRead(12'h300, r);
    check("R10 reserved stored", r, 32'h00000700);
    check("R10 reserved not sent", {31'h0, msgValid}, 32'h0);

    // Random mix
    for (int it = 0; it < 80; it++) begin
      id = $urandom % (NUM_CPU + 2);
      dest = $urandom % (NUM_CPU + 2);
      en = ($urandom % 4) != 0;
      busWrite(12'h020, 32'(id) << 24);
      busWrite(12'h0F0, {23'h0, en, 8'($urandom)});
      busWrite(12'h310, 32'(dest) << 24);
      w = $urandom & 32'hFFFFEFFF;
      if (($urandom % 6) != 0) w[11] = 1'b0;
      busWrite(12'h300, w);
      busRead(12'h300, r);
      selfNum = id;
      if (expSend(en, w)) begin
        check("R6 pending bit set", r, (w & 32'h000CCFFF) | 32'h1000);
        check("R6 valid", {31'h0, msgValid}, 32'h1);
        check("R7 target mask", 32'(msgTargets), 32'(expMask(int'(w[19:18]), selfNum, dest)));
        check("R6 payload", {19'h0, msgTrigger, msgLevel, msgMode, msgVector},
              {19'h0, w[15], w[14], w[10:8], w[7:0]});
        drain($urandom % 4, expMask(int'(w[19:18]), selfNum, dest), w & 32'h000CCFFF);
      end else begin
        check("R10 R11 R12 no send", {31'h0, msgValid}, 32'h0);
        check("R5 stored without send", r, w & 32'h000CCFFF);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule